// File: doc/BRIEF.md
# Self-Clearing Counter Clear Register

This block is a control register through which a host resets a set of counters on demand. Each low bit of the register stands for one counter. Writing 1 to such a bit starts a clear of that counter. The bit reads back as 1 while the clear is pending and drops to 0 by itself once the clear is done, so the host never has to write it back. The block never clears a counter unless the host asks for it.

Two of the counters are time counters, one for discharge and one for charge. Each of them has a sticky status flag and a count-rate selection. Clearing either time counter also drops its sticky flag and returns its rate selection to the default code. The upper bits of the register carry a temperature code supplied from outside. Those bits are read-only.

In this block the counters are plain registers. Each counter advances on its own increment strobe and wraps at its maximum value. The block exports its clear strobes so that neighbouring logic can follow each clear.

Top module: `ctr_clear_reg`

## Requirements
- R1: After a synchronous active-low reset, all request bits read 0, every counter holds 0, both sticky flags are 0 and both rate selections equal RATE_DEF (default 3).
- R2: A write that carries 1 in bit i (i < N_CLR) raises clr_o[i] and makes bit i read 1 in the cycle after the write edge. Counter i then holds 0 from the following edge on.
- R3: A request bit returns to 0 one cycle after it was set, with no host write needed.
- R4: Writing 0 to a request bit has no effect. When several bits are written as 1 in one write, all of them are serviced in the same cycle.
- R5: A read in the same cycle as a write returns the value from before the write.
- R6: Register bits [REG_W-1:N_CLR] always show temp_i, and host writes to them are ignored.
- R7: A clear of bit 0 (the discharge time counter) also clears sticky_o[0] and restores rate_o[RATE_W-1:0] to RATE_DEF.
- R8: A clear of bit 1 (the charge time counter) also clears sticky_o[1] and restores rate_o[2*RATE_W-1:RATE_W] to RATE_DEF.
- R9: A clear takes priority over a same-cycle increment, sticky set or rate load on the same counter.
- R10: A counter with no clear pending never resets by itself. It holds its value when idle and advances by 1 (wrapping) on its increment strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | REG_W | Host write data. Bit i requests a clear of counter i. |
| rd_data_o | output | REG_W | Register read value: {temperature, request bits} |
| temp_i | input | TEMP_W | Temperature code shown in the upper register bits |
| inc_i | input | N_CLR | Per-counter increment strobes |
| cnt_o | output | N_CLR*CNT_W | Counter values, counter i at [i*CNT_W +: CNT_W] |
| clr_o | output | N_CLR | Per-counter clear strobes |
| sticky_set_i | input | 2 | Sets the sticky flags (bit 0 discharge, bit 1 charge) |
| sticky_o | output | 2 | Sticky status flags |
| rate_ld_i | input | 2 | Loads rate_val_i into the rate selection of time counter j |
| rate_val_i | input | RATE_W | Rate code to load |
| rate_o | output | 2*RATE_W | Rate selections, time counter j at [j*RATE_W +: RATE_W] |

## Verification
A write at edge k shows up in the request bits and on clr_o immediately after edge k. The counter, its sticky flag and its rate selection take their cleared values after edge k+1, and the request bit reads 0 again at that same point. The temperature field and the same-cycle read are combinational, so they are due in the cycle the stimulus is applied. The bench drives its inputs 1 ns after the falling edge. A behavioural model advances on each rising edge, and every output is compared against that model at each falling edge, where all these results have settled. Directed checks sample at the same points: the read-during-write check comes before the edge, and the clear results come one and two edges after it.

// File: rtl/ctr_clear_pkg.sv
// Package: shared constants for the counter clear register.
// Assumes the two time counters occupy the lowest request bits.
package ctr_clear_pkg;
    localparam int IDX_DSG_TIME = 0;   // discharge time counter request bit
    localparam int IDX_CHG_TIME = 1;   // charge time counter request bit
    localparam int N_TIMED      = 2;   // counters carrying sticky flag and rate
endpackage

// File: rtl/ccr_req_reg.sv
// Module: ccr_req_reg
// Holds the pending clear requests and forms the read word.
// Every request is serviced in the cycle after it is written, so the
// pending bits live for exactly one cycle. The temperature field is a
// live view of temp_i and cannot be written.
module ccr_req_reg #(
    parameter int N_CLR  = 5,
    parameter int TEMP_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [N_CLR-1:0]          wr_req,
    input  logic [TEMP_W-1:0]         temp,
    output logic [N_CLR-1:0]          pend_o,
    output logic [N_CLR+TEMP_W-1:0]   rd_data_o
);
    logic [N_CLR-1:0] pend_q;

    // Capture written 1s; anything pending is serviced and dropped next edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (wr_en)
            pend_q <= wr_req;
        else
            pend_q <= '0;
    end

    // Read word: temperature on top, request bits below.
    always_comb begin
        rd_data_o = {temp, pend_q};
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/ccr_counter.sv
// Module: ccr_counter
// A plain wrapping counter standing in for a measured quantity.
// A clear has priority over an increment in the same cycle.
module ccr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count on the increment strobe, zero on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/ccr_timed_ctl.sv
// Module: ccr_timed_ctl
// Sticky status flag and count-rate selection of one time counter.
// A clear drops the flag and restores the default rate. The clear
// wins over a set or load in the same cycle.
module ccr_timed_ctl #(
    parameter int              RATE_W   = 3,
    parameter logic [RATE_W-1:0] RATE_DEF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sticky_set,
    input  logic              rate_ld,
    input  logic [RATE_W-1:0] rate_val,
    output logic              sticky_o,
    output logic [RATE_W-1:0] rate_o
);
    logic              sticky_q;
    logic [RATE_W-1:0] rate_q;

    // Sticky flag: set by event, cleared only with the counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sticky_q <= 1'b0;
        else if (sticky_set)
            sticky_q <= 1'b1;
    end

    // Rate selection: loaded from outside, defaulted on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            rate_q <= RATE_DEF;
        else if (rate_ld)
            rate_q <= rate_val;
    end

    assign sticky_o = sticky_q;
    assign rate_o   = rate_q;
endmodule

// File: rtl/ctr_clear_reg.sv
// Module: ctr_clear_reg (top)
// Host-writable clear register with self-clearing request bits. It
// drives the counters it clears, and the sticky flags and rate
// selections of the two time counters.
// Assumes N_CLR >= 2, with the time counters at request bits 0 and 1.
module ctr_clear_reg #(
    parameter int N_CLR    = 5,
    parameter int CNT_W    = 8,
    parameter int TEMP_W   = 3,
    parameter int RATE_W   = 3,
    parameter int RATE_DEF = 3,
    localparam int REG_W   = N_CLR + TEMP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [REG_W-1:0]        wr_data_i,
    output logic [REG_W-1:0]        rd_data_o,
    input  logic [TEMP_W-1:0]       temp_i,
    input  logic [N_CLR-1:0]        inc_i,
    output logic [N_CLR*CNT_W-1:0]  cnt_o,
    output logic [N_CLR-1:0]        clr_o,
    input  logic [1:0]              sticky_set_i,
    output logic [1:0]              sticky_o,
    input  logic [1:0]              rate_ld_i,
    input  logic [RATE_W-1:0]       rate_val_i,
    output logic [2*RATE_W-1:0]     rate_o
);
    import ctr_clear_pkg::*;

    localparam logic [RATE_W-1:0] RATE_DEF_C = RATE_W'(RATE_DEF);

    logic [N_CLR-1:0] pend;
    logic             unused_ro_bits;

    // Writes to the read-only temperature bits are dropped here.
    assign unused_ro_bits = ^wr_data_i[REG_W-1:N_CLR];

    ccr_req_reg #(.N_CLR(N_CLR), .TEMP_W(TEMP_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .wr_req    (wr_data_i[N_CLR-1:0]),
        .temp      (temp_i),
        .pend_o    (pend),
        .rd_data_o (rd_data_o)
    );

    // One counter per request bit.
    for (genvar i = 0; i < N_CLR; i++) begin : g_cnt
        ccr_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (pend[i]),
            .inc   (inc_i[i]),
            .cnt_o (cnt_o[i*CNT_W +: CNT_W])
        );
    end

    // Flag and rate state for the discharge and charge time counters.
    for (genvar j = 0; j < N_TIMED; j++) begin : g_timed
        ccr_timed_ctl #(.RATE_W(RATE_W), .RATE_DEF(RATE_DEF_C)) u_tctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (pend[(j == 0) ? IDX_DSG_TIME : IDX_CHG_TIME]),
            .sticky_set (sticky_set_i[j]),
            .rate_ld    (rate_ld_i[j]),
            .rate_val   (rate_val_i),
            .sticky_o   (sticky_o[j]),
            .rate_o     (rate_o[j*RATE_W +: RATE_W])
        );
    end

    assign clr_o = pend;
endmodule

// File: rtl/ctr_clear_reg_chk.sv
// Module: ctr_clear_reg_chk
// Assertion checker for ctr_clear_reg, attached through bind.
module ctr_clear_reg_chk #(
    parameter int N_CLR    = 5,
    parameter int CNT_W    = 8,
    parameter int TEMP_W   = 3,
    parameter int RATE_W   = 3,
    parameter int RATE_DEF = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en_i,
    input logic [N_CLR+TEMP_W-1:0]       wr_data_i,
    input logic [N_CLR+TEMP_W-1:0]       rd_data_o,
    input logic [TEMP_W-1:0]             temp_i,
    input logic [N_CLR-1:0]              inc_i,
    input logic [N_CLR*CNT_W-1:0]        cnt_o,
    input logic [N_CLR-1:0]              clr_o,
    input logic [1:0]                    sticky_o,
    input logic [2*RATE_W-1:0]           rate_o
);
    // R2: written 1s appear as clear strobes on the next cycle.
    p_strobe_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> clr_o == $past(wr_data_i[N_CLR-1:0]));

    // R3: with no write, pending requests vanish after one cycle.
    p_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> clr_o == '0);

    // R3: request bits read back match the strobes.
    p_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[N_CLR-1:0] == clr_o);

    // R6: the temperature field is a live view of the input.
    p_temp_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[N_CLR+TEMP_W-1:N_CLR] == temp_i);

    // R7: discharge time clear drops its flag and restores the rate.
    p_dsg_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o[0] |=> !sticky_o[0] && rate_o[RATE_W-1:0] == RATE_W'(RATE_DEF));

    // R8: charge time clear drops its flag and restores the rate.
    p_chg_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o[1] |=> !sticky_o[1] && rate_o[2*RATE_W-1:RATE_W] == RATE_W'(RATE_DEF));

    for (genvar i = 0; i < N_CLR; i++) begin : g_chk
        // R2 / R9: a cleared counter reads 0, increment or not.
        p_cnt_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            clr_o[i] |=> cnt_o[i*CNT_W +: CNT_W] == '0);
        // R10: no clear and no increment means the counter holds.
        p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_o[i] && !inc_i[i] |=> $stable(cnt_o[i*CNT_W +: CNT_W]));
    end
endmodule

bind ctr_clear_reg ctr_clear_reg_chk #(
    .N_CLR(N_CLR), .CNT_W(CNT_W), .TEMP_W(TEMP_W),
    .RATE_W(RATE_W), .RATE_DEF(RATE_DEF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .temp_i(temp_i), .inc_i(inc_i), .cnt_o(cnt_o),
    .clr_o(clr_o), .sticky_o(sticky_o), .rate_o(rate_o)
);

// File: tb/ctr_clear_reg_bench.sv
// Bench for ctr_clear_reg: behavioural model compared every cycle,
// plus directed checks for each requirement.
module ctr_clear_reg_bench;
    localparam int NC = 5, CW = 8, TW = 3, RW = 3, RDEF = 3;
    localparam int RGW = NC + TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [RGW-1:0] wr_data = '0;
    logic [RGW-1:0] rd_data;
    logic [TW-1:0] temp = '0;
    logic [NC-1:0] inc = '0;
    logic [NC*CW-1:0] cnt;
    logic [NC-1:0] clr;
    logic [1:0] sset = '0, sticky, rld = '0;
    logic [RW-1:0] rval = '0;
    logic [2*RW-1:0] rate;

    always #5 clk = ~clk;

    ctr_clear_reg #(.N_CLR(NC), .CNT_W(CW), .TEMP_W(TW), .RATE_W(RW),
                    .RATE_DEF(RDEF)) u_ctr_clear_reg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .temp_i(temp), .inc_i(inc), .cnt_o(cnt),
        .clr_o(clr), .sticky_set_i(sset), .sticky_o(sticky),
        .rate_ld_i(rld), .rate_val_i(rval), .rate_o(rate));

    int nchk = 0, nerr = 0;
    bit live = 0;

    // Reference model state.
    int m_pend;
    int m_cnt[NC];
    int m_sticky[2];
    int m_rate[2];

    task automatic chk(input int act, input int exp, input string req);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model advances on each rising edge from the spec rules.
    always @(posedge clk) begin
        int np;
        if (!rst_n) begin
            m_pend = 0;
            for (int i = 0; i < NC; i++) m_cnt[i] = 0;
            for (int j = 0; j < 2; j++) begin m_sticky[j] = 0; m_rate[j] = RDEF; end
        end else begin
            np = wr_en ? int'(wr_data) & ((1 << NC) - 1) : 0;
            for (int i = 0; i < NC; i++)
                if ((m_pend >> i) & 1) m_cnt[i] = 0;
                else if (inc[i]) m_cnt[i] = (m_cnt[i] + 1) % (1 << CW);
            for (int j = 0; j < 2; j++)
                if ((m_pend >> j) & 1) begin m_sticky[j] = 0; m_rate[j] = RDEF; end
                else begin
                    if (sset[j]) m_sticky[j] = 1;
                    if (rld[j]) m_rate[j] = int'(rval);
                end
            m_pend = np;
        end
    end

    // Full comparison at every falling edge.
    always @(negedge clk) begin
        if (live) begin
            chk(int'(rd_data[NC-1:0]), m_pend, "R3 request bits");
            chk(int'(rd_data[RGW-1:NC]), int'(temp), "R6 temperature field");
            chk(int'(clr), m_pend, "R2 clear strobes");
            for (int i = 0; i < NC; i++)
                chk(int'(cnt[i*CW +: CW]), m_cnt[i], "R10 counter value");
            chk(int'(sticky[0]), m_sticky[0], "R7 discharge sticky");
            chk(int'(rate[RW-1:0]), m_rate[0], "R7 discharge rate");
            chk(int'(sticky[1]), m_sticky[1], "R8 charge sticky");
            chk(int'(rate[2*RW-1:RW]), m_rate[1], "R8 charge rate");
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        live = 1;
        tick();
        // R1: reset state
        chk(int'(rd_data[NC-1:0]), 0, "R1 request bits");
        chk(int'(cnt), 0, "R1 counters");
        chk(int'(sticky), 0, "R1 sticky");
        chk(int'(rate), (RDEF << RW) | RDEF, "R1 rate");

        // Build up state: counts 5, flags set, rates 6.
        inc = '1; sset = 2'b11; rld = 2'b11; rval = 3'd6;
        repeat (5) tick();
        inc = '0; sset = '0; rld = '0;
        tick();

        // R4: writing zeros changes nothing.
        wr_en = 1'b1; wr_data = '0;
        tick();
        wr_en = 1'b0;
        tick();
        chk(int'(clr), 0, "R4 zero write strobes");
        chk(int'(cnt[0 +: CW]), 5, "R4 zero write counter");
        chk(int'(sticky), 3, "R4 zero write sticky");

        // R5 / R2 / R3 / R7: clear discharge time counter.
        wr_en = 1'b1; wr_data = 8'h01;
        chk(int'(rd_data[NC-1:0]), 0, "R5 read during write");
        tick();
        wr_en = 1'b0;
        chk(int'(rd_data[0]), 1, "R2 request bit set");
        chk(int'(clr), 1, "R2 strobe");
        tick();
        chk(int'(rd_data[0]), 0, "R3 self clear");
        chk(int'(cnt[0 +: CW]), 0, "R2 counter cleared");
        chk(int'(cnt[CW +: CW]), 5, "R10 other counter held");
        chk(int'(sticky[0]), 0, "R7 sticky cleared");
        chk(int'(rate[RW-1:0]), RDEF, "R7 rate default");
        chk(int'(sticky[1]), 1, "R7 charge flag untouched");

        // R8: clear charge time counter.
        wr_en = 1'b1; wr_data = 8'h02;
        tick();
        wr_en = 1'b0;
        tick();
        chk(int'(cnt[CW +: CW]), 0, "R8 counter cleared");
        chk(int'(sticky[1]), 0, "R8 sticky cleared");
        chk(int'(rate[2*RW-1:RW]), RDEF, "R8 rate default");

        // R4 / R6: clear all at once, with temperature bits written too.
        inc = '1; repeat (3) tick(); inc = '0;
        temp = 3'd5;
        wr_en = 1'b1; wr_data = 8'hFF;
        tick();
        wr_en = 1'b0;
        chk(int'(rd_data[RGW-1:NC]), 5, "R6 temperature read-only");
        chk(int'(clr), 5'h1F, "R4 all strobes together");
        tick();
        chk(int'(cnt), 0, "R4 all counters cleared");

        // R9: clear versus same-cycle increment, set and load.
        inc = '1; sset = 2'b11; rld = 2'b11; rval = 3'd7;
        wr_en = 1'b1; wr_data = 8'h03;
        tick();
        wr_en = 1'b0;
        tick();
        inc = '0; sset = '0; rld = '0;
        chk(int'(cnt[0 +: CW]), 0, "R9 counter clear wins");
        chk(int'(cnt[2*CW +: CW]), 2, "R9 uncleared counter advanced");
        chk(int'(sticky), 0, "R9 sticky clear wins");
        chk(int'(rate), (RDEF << RW) | RDEF, "R9 rate clear wins");

        // Random traffic against the model.
        for (int n = 0; n < 400; n++) begin
            wr_en = ($urandom % 4) == 0;
            wr_data = RGW'($urandom);
            temp = TW'($urandom);
            inc = NC'($urandom);
            sset = 2'($urandom % 4 == 0 ? $urandom : 0);
            rld = 2'($urandom % 3 == 0 ? $urandom : 0);
            rval = RW'($urandom);
            tick();
        end
        wr_en = 1'b0; inc = '0; sset = '0; rld = '0;
        tick();
        finish_run();
    end
endmodule